// File: doc/BRIEF.md
# Serially Loaded Coefficient Register File

This block stores 32 rows of filter coefficients, each row holding four 11-bit two's complement values that feed four downstream multipliers. Rows are written through a three-wire serial port: a serial clock, an active-low serial enable and a data bit. One 64-bit frame, made of four 16-bit words sent MSB first, carries a target row number and four coefficients. The row is written only once all 64 bits have arrived, and then all four values are written together.

The serial port runs on its own clock. When a frame completes, its contents are held in a staging register in the serial domain. A toggle, passed through a two-flop synchronizer, tells the system-clock domain to copy them into the store, so the read side never sees a half-written row. On the read side, a row-select register loads when its active-low load input is low. The selected row appears on the coefficient output one system clock later.

Top module: `coef_file`

## Requirements
- R1: After reset every row reads as zero and `coef_out` is zero.
- R2: Bits are shifted only on a rising `sclk` edge while `ser_en_n` is low. Serial clocks with `ser_en_n` high change no stored row.
- R3: Within a frame, bits 15:11 of the first word give the target row. The low 11 bits of the four words go to registers 4, 3, 2 and 1 in that order. Register k appears on `coef_out[(k-1)*11 +: 11]`.
- R4: Bits 15:11 of the second, third and fourth words have no effect on what is stored.
- R5: A row is written only after the 64th bit. Raising `ser_en_n` before then discards the partial frame, and the next frame starts counting from bit 1.
- R6: With `ser_en_n` held low, consecutive frames each write their own row.
- R7: After reset, shifting stays disabled until `ser_en_n` has been sampled high on a rising `sclk` edge. This makes a high-to-low transition of the enable a condition for loading.
- R8: `row_sel` loads `rd_row` on a rising `clk` edge while `rd_load_n` is low, and holds its value while `rd_load_n` is high.
- R9: `coef_out` shows the row held in `row_sel` one `clk` edge after `row_sel` loads. It therefore appears two edges after the address is presented.
- R10: A completed frame becomes visible on `coef_out` for the selected row within 10 `clk` cycles of the final serial bit's rising `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the store and the read side |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| sclk | input | 1 | Serial shift clock |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_din | input | 1 | Serial data bit, MSB of each word first |
| rd_row | input | 5 | Row number for the read side |
| rd_load_n | input | 1 | Active-low load enable for the row-select register |
| coef_out | output | 44 | Four coefficients of the selected row, register 1 in the low bits |

## Verification
The hardest case to reach from the ports is a frame that has been shifted in but not yet committed. The bench holds the enable low after exactly 63 bits and reads the target row, which must still be zero. Only then does it send the 64th bit and check that the row appears. A second case is a partial frame cut off by the enable going high, followed by a complete frame to another row. This shows that the bit counter restarted and that the stale bits did not shift the new frame out of place.

// File: rtl/coef_file.sv
module coef_file #(
  parameter int ROWS = 32,
  parameter int CW   = 11,
  parameter int NC   = 4,
  parameter int WW   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      ser_en_n,
  input  logic                      ser_din,
  input  logic [$clog2(ROWS)-1:0]   rd_row,
  input  logic                      rd_load_n,
  output logic [NC*CW-1:0]          coef_out
);
  localparam int AW   = $clog2(ROWS);
  localparam int FB   = NC * WW;
  localparam int CNTW = $clog2(FB);
  localparam logic [CNTW-1:0] LAST = CNTW'(FB - 1);

  // serial clock domain
  logic [FB-2:0]    sh;
  logic [CNTW-1:0]  cnt;
  logic             armed;
  logic             req_t;
  logic [AW-1:0]    hold_row;
  logic [NC*CW-1:0] hold_dat;
  logic [NC*CW-1:0] frame_dat;
  logic [AW-1:0]    frame_row;

  assign frame_row = sh[FB-2 -: AW];

  for (genvar i = 0; i < NC; i++) begin : g_lane
    if (i == 0) begin : g_last_word
      assign frame_dat[CW-1:0] = {sh[CW-2:0], ser_din};
    end else begin : g_word
      assign frame_dat[i*CW +: CW] = sh[i*WW-1 +: CW];
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      armed    <= 1'b0;
      req_t    <= 1'b0;
      hold_row <= '0;
      hold_dat <= '0;
    end else if (ser_en_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      sh  <= {sh[FB-3:0], ser_din};
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == LAST) begin
        hold_row <= frame_row;
        hold_dat <= frame_dat;
        req_t    <= ~req_t;
      end
    end
  end

  // system clock domain
  logic [2:0]       sy;
  logic             wr_pulse;
  logic [AW-1:0]    row_sel;
  logic [NC*CW-1:0] mem [ROWS];

  assign wr_pulse = sy[2] ^ sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], req_t};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_pulse) begin
      mem[hold_row] <= hold_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel  <= '0;
      coef_out <= '0;
    end else begin
      if (!rd_load_n) row_sel <= rd_row;
      coef_out <= mem[row_sel];
    end
  end
endmodule

module coef_file_chk #(
  parameter int AW   = 5,
  parameter int CNTW = 6,
  parameter int DW   = 44
) (
  input logic            clk,
  input logic            sclk,
  input logic            rst_n,
  input logic            ser_en_n,
  input logic            armed,
  input logic [CNTW-1:0] cnt,
  input logic            req_t,
  input logic            wr_pulse,
  input logic            rd_load_n,
  input logic [AW-1:0]   rd_row,
  input logic [AW-1:0]   row_sel,
  input logic [DW-1:0]   coef_out
);
  localparam logic [CNTW-1:0] LASTC = {CNTW{1'b1}};

  p_cnt_clear_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    ser_en_n |=> (cnt == '0));

  p_commit_full_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    !(cnt == LASTC && !ser_en_n && armed) |=> $stable(req_t));

  p_unarmed_idle_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    !armed |-> (cnt == '0));

  p_row_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load_n |=> (row_sel == $past(rd_row)));

  p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load_n |=> $stable(row_sel));

  p_out_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(row_sel) && !$past(wr_pulse)) |=> $stable(coef_out));

  p_single_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

bind coef_file coef_file_chk #(.AW(AW), .CNTW(CNTW), .DW(NC*CW)) u_chk (
  .clk(clk), .sclk(sclk), .rst_n(rst_n), .ser_en_n(ser_en_n),
  .armed(armed), .cnt(cnt), .req_t(req_t), .wr_pulse(wr_pulse),
  .rd_load_n(rd_load_n), .rd_row(rd_row), .row_sel(row_sel),
  .coef_out(coef_out)
);

// File: tb/coef_file_tb.sv
module coef_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        ser_en_n = 1'b0;
  logic        ser_din = 1'b0;
  logic [4:0]  rd_row = '0;
  logic        rd_load_n = 1'b1;
  logic [43:0] coef_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  coef_file u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .rd_row(rd_row), .rd_load_n(rd_load_n), .coef_out(coef_out));

  // {row, reg4, reg3, reg2, reg1}; low 44 bits equal the expected coef_out
  localparam logic [48:0] VEC [6] = '{
    {5'd2,  11'h7EC, 11'h08C, 11'h1A4, 11'h7E4},
    {5'd0,  11'h400, 11'h3FF, 11'h001, 11'h000},
    {5'd31, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF},
    {5'd17, 11'h123, 11'h456, 11'h000, 11'h7FF},
    {5'd5,  11'h2AA, 11'h555, 11'h2AA, 11'h555},
    {5'd30, 11'h001, 11'h002, 11'h004, 11'h400}
  };

  function automatic logic [63:0] mkframe(input logic [48:0] v, input logic [4:0] junk);
    return {v[48:44], v[43:33], junk, v[32:22], junk, v[21:11], junk, v[10:0]};
  endfunction

  task automatic check(input string req, input logic [43:0] act, input logic [43:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    ser_din = b; #10; sclk = 1'b1; #20; sclk = 1'b0; #10;
  endtask

  task automatic send(input logic [63:0] f, input int n);
    for (int k = 63; k > 63 - n; k--) sbit(f[k]);
  endtask

  task automatic frame_once(input logic [63:0] f);
    ser_en_n = 1'b0; send(f, 64); ser_en_n = 1'b1; sbit(1'b0);
    repeat (10) @(negedge clk);
  endtask

  task automatic read_row(input logic [4:0] r);
    @(negedge clk); rd_row = r; rd_load_n = 1'b0;
    @(negedge clk); rd_load_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 output after reset", coef_out, '0);
    read_row(5'd9);
    check("R1 row 9 after reset", coef_out, '0);

    // R7: enable low since reset, never seen high: frame must be ignored
    send(mkframe({5'd7, 44'h123_4567_89A}, 5'h0), 64);
    ser_en_n = 1'b1; sbit(1'b0);
    repeat (10) @(negedge clk);
    read_row(5'd7);
    check("R7 frame before arming ignored", coef_out, '0);

    // worked bit stream for row 2, don't-care bits sent as ones (R3, R4)
    frame_once(64'h17EC_F88C_F9A4_FFE4);
    read_row(5'd2);
    check("R3 worked stream row 2", coef_out, {11'h7EC, 11'h08C, 11'h1A4, 11'h7E4});

    // table walk: R3 field placement, R4 varied don't-care bits
    for (int i = 0; i < 6; i++) begin
      frame_once(mkframe(VEC[i], 5'(i * 11 + 5)));
      read_row(VEC[i][48:44]);
      check($sformatf("R3 R4 table row %0d", VEC[i][48:44]), coef_out, VEC[i][43:0]);
    end

    // R2: serial clocks with enable high change nothing
    send(mkframe({5'd17, 44'h0}, 5'h1F), 64);
    repeat (10) @(negedge clk);
    read_row(5'd17);
    check("R2 enable high no change", coef_out, VEC[3][43:0]);

    // R5: partial frame discarded, then full frame aligned from bit 1
    ser_en_n = 1'b0; send(mkframe({5'd9, 44'hFFF_FFFF_FFF}, 5'h0), 40);
    ser_en_n = 1'b1; sbit(1'b1);
    frame_once(mkframe({5'd10, 11'h111, 11'h222, 11'h333, 11'h444}, 5'h3));
    read_row(5'd9);
    check("R5 partial frame row 9 untouched", coef_out, '0);
    read_row(5'd10);
    check("R5 frame after partial", coef_out, {11'h111, 11'h222, 11'h333, 11'h444});

    // R5: 63 bits in, nothing written yet; 64th bit commits
    read_row(5'd11);
    ser_en_n = 1'b0; send(mkframe({5'd11, 11'h0AB, 11'h0CD, 11'h0EF, 11'h012}, 5'h0), 63);
    repeat (12) @(negedge clk);
    check("R5 no write after 63 bits", coef_out, '0);
    sbit(1'b0);
    ser_en_n = 1'b1;
    @(negedge clk);
    check("R10 row visible soon after final bit", coef_out, {11'h0AB, 11'h0CD, 11'h0EF, 11'h012});

    // R6: back-to-back frames with enable held low
    ser_en_n = 1'b0;
    send(mkframe({5'd12, 11'h701, 11'h702, 11'h703, 11'h704}, 5'h15), 64);
    send(mkframe({5'd13, 11'h005, 11'h006, 11'h007, 11'h008}, 5'h0A), 64);
    ser_en_n = 1'b1; sbit(1'b0);
    repeat (10) @(negedge clk);
    read_row(5'd12);
    check("R6 first of back-to-back", coef_out, {11'h701, 11'h702, 11'h703, 11'h704});
    read_row(5'd13);
    check("R6 second of back-to-back", coef_out, {11'h005, 11'h006, 11'h007, 11'h008});

    // R9: output follows one edge after the row register loads
    read_row(5'd2);
    rd_row = 5'd31; rd_load_n = 1'b0;
    @(negedge clk); rd_load_n = 1'b1;
    check("R9 old row after one edge", coef_out, VEC[0][43:0]);
    @(negedge clk);
    check("R9 new row after two edges", coef_out, VEC[2][43:0]);

    // R8: load disabled holds the selected row
    rd_row = 5'd0;
    repeat (4) @(negedge clk);
    check("R8 row held while load high", coef_out, VEC[2][43:0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule